// File: doc/BRIEF.md
# Audio DMA Descriptor-Ring Channel Controller

This block keeps the software-visible registers of one audio DMA channel and sequences the channel through a ring of buffer descriptors. Software sets a base address, raises a last-valid index and starts the channel. A separate data engine, which fetches descriptors and moves samples, sends one pulse each time a buffer finishes. With that pulse it gives the finished descriptor's interrupt-on-completion flag and the length of the buffer that comes next.

On each pulse the controller advances the current index around the ring. When the current index has caught up with the last-valid index, the channel halts itself and flags end-of-list. It resumes by itself as soon as software moves the last-valid index ahead. A level interrupt request is recomputed only when one of the interrupt status bits changes.

Registers are reached through a 32-bit port with a dword address and per-byte enables, so byte, word and dword accesses all map onto one write strobe. Reads are combinational. Register map, by dword address:
- 0: base address.
- 1: current index in [7:0], last-valid index in [15:8], status in [31:16].
- 2: remaining sample count in [15:0], prefetched index in [23:16], control in [31:24].
- 3: reads zero.

Top module: `audio_ring_ctrl`

## Requirements
- R1: After reset, dword 0 reads 0. Dwords 1 and 2 each read 0x00010000: status is halted only (bit 0), both indices and the count are 0, the prefetched index is 1 and control is 0. The run output and the interrupt output are low.
- R2: The base address keeps bits [2:0] at zero whatever is written. Each byte lane is written only when its byte enable is set.
- R3: The last-valid index stores only the low 5 bits of the byte written, so 0x25 reads back as 0x05.
- R4: Status bits 2 (last-valid completion), 3 (buffer completion) and 4 (FIFO error) are cleared by writing 1. Writing 1 to bit 0 (halted) or bit 1 (current equals last valid) has no effect. Writing 0xFFFF to status after reset reads back 0x0001.
- R5: Writing control bit 0 (run) from 0 to 1 sets the current index to 0, the prefetched index to 1 and clears halted. Writing run = 0 sets halted. The run output follows control bit 0.
- R6: Writing control bit 1 (register reset) returns the base, the indices, the count and control to their R1 values and sets the status to 0x0001.
- R7: A completion pulse while not halted, with the current index different from the last-valid index, does four things. It clears status bit 1. It sets status bit 3 if the interrupt-on-completion flag is high. It advances the current index by one modulo 32, with the prefetched index following at current + 1 modulo 32. It loads the count from the next-length input.
- R8: A completion pulse while not halted, with the current index equal to the last-valid index, sets status bits 0, 1 and 2 and leaves the current index unchanged.
- R9: Writing the last-valid index while run is set, the channel is halted and the new value differs from the current index clears status bits 0 and 1.
- R10: The interrupt output is recomputed only when status bits 2 to 4 change. It then goes high if bit 2 and control bit 3 are both set, or if bit 3 and control bit 4 are both set; otherwise it goes low. A change to control alone leaves it as it is.
- R11: Writes to the current index, the prefetched index and the count bytes have no effect.
- R12: A completion pulse while halted changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Dword address |
| reg_be_i | input | 4 | Byte enables of the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| done_i | input | 1 | Buffer-completed pulse from the data engine |
| done_ioc_i | input | 1 | Interrupt-on-completion flag of the completed descriptor |
| done_len_i | input | 16 | Sample length of the next buffer |
| run_o | output | 1 | Channel run flag |
| irq_o | output | 1 | Channel interrupt request |

## Verification
A wrong current index shows up in the read port on the next cycle. Because the bench walks the full 32-entry ring and wraps past entry 31, an off-by-one or a wrong wrap is caught at the step where it first happens. A wrong halted or end-of-list bit shows up as a missing stop at the last-valid entry, or as a failed self-restart. That mistake also changes what the data engine would be allowed to do next, so it must be seen on the cycle after the pulse. A wrong interrupt evaluation only becomes visible when a status change coincides with a particular enable setting, so the bench sets up the cases where control changes alone and where a completion leaves the interrupt bits untouched.

// File: rtl/audio_ring_pkg.sv
package audio_ring_pkg;
  localparam int unsigned STAT_W   = 5;
  localparam int unsigned CTRL_W   = 5;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned BASE_LSB = 3;

  // status bit positions
  localparam int unsigned ST_HALT  = 0;
  localparam int unsigned ST_CELV  = 1;
  localparam int unsigned ST_LVBC  = 2;
  localparam int unsigned ST_BCMP  = 3;
  localparam int unsigned ST_FERR  = 4;

  // control bit positions
  localparam int unsigned CT_RUN   = 0;
  localparam int unsigned CT_RST   = 1;
  localparam int unsigned CT_FEN   = 2;
  localparam int unsigned CT_LVEN  = 3;
  localparam int unsigned CT_BCEN  = 4;

  typedef enum logic [1:0] {
    DW_BASE  = 2'd0,
    DW_INDEX = 2'd1,
    DW_COUNT = 2'd2,
    DW_NONE  = 2'd3
  } dword_sel_e;
endpackage

// File: rtl/arc_base_reg.sv
module arc_base_reg
  import audio_ring_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [3:0]       be_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             clr_i,
  output logic [REG_W-1:0] base_o
);
  localparam int unsigned LANES = REG_W / 8;

  logic [REG_W-1:0] base_q;
  logic [REG_W-1:0] base_d;
  logic             base_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign base_d[g*8 +: 8] = clr_i              ? 8'h00 :
                              (wr_i && be_i[g])  ? wdata_i[g*8 +: 8] :
                                                   base_q[g*8 +: 8];
  end

  assign base_en = clr_i | (wr_i & (|be_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= {base_d[REG_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
    end
  end

  assign base_o = base_q;
endmodule

// File: rtl/arc_irq_eval.sv
module arc_irq_eval (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] int_old_i,  // {fifo err, buffer cmp, last-valid cmp}
  input  logic [2:0] int_new_i,
  input  logic       lv_en_i,
  input  logic       bc_en_i,
  output logic       irq_o
);
  logic irq_q;
  logic irq_d;
  logic eval_en;

  assign eval_en = (int_old_i != int_new_i);

  always_comb begin
    irq_d = irq_q;
    if (eval_en) begin
      irq_d = (int_new_i[0] & lv_en_i) | (int_new_i[1] & bc_en_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else if (eval_en) begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/arc_rd_mux.sv
module arc_rd_mux
  import audio_ring_pkg::*;
#(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned LEN_W = 16
) (
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] base_i,
  input  logic [IDX_W-1:0] civ_i,
  input  logic [IDX_W-1:0] lvi_i,
  input  logic [IDX_W-1:0] piv_i,
  input  logic [STAT_W-1:0] st_i,
  input  logic [CTRL_W-1:0] ctl_i,
  input  logic [LEN_W-1:0] cnt_i,
  output logic [REG_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (dword_sel_e'(addr_i))
      DW_BASE:  rdata_o = base_i;
      DW_INDEX: rdata_o = {16'(st_i), 8'(lvi_i), 8'(civ_i)};
      DW_COUNT: rdata_o = {8'(ctl_i), 8'(piv_i), 16'(cnt_i)};
      DW_NONE:  rdata_o = '0;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/audio_ring_ctrl.sv
module audio_ring_ctrl
  import audio_ring_pkg::*;
#(
  parameter int unsigned RING_DEPTH = 32,  // power of two
  parameter int unsigned LEN_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [3:0]       reg_be_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             done_i,
  input  logic             done_ioc_i,
  input  logic [LEN_W-1:0] done_len_i,
  output logic             run_o,
  output logic             irq_o
);
  localparam int unsigned IDX_W = $clog2(RING_DEPTH);
  localparam logic [STAT_W-1:0] ST_RESET = STAT_W'(1) << ST_HALT;

  logic [IDX_W-1:0]  civ_q, civ_d, lvi_q, lvi_d, piv_w;
  logic [STAT_W-1:0] st_q, st_d;
  logic [CTRL_W-1:0] ctl_q, ctl_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [REG_W-1:0]  base_w;
  logic              wr_base, wr_idx, wr_ctl, regs_clr, state_en;

  assign wr_base  = reg_wr_i && (reg_addr_i == DW_BASE);
  assign wr_idx   = reg_wr_i && (reg_addr_i == DW_INDEX);
  assign wr_ctl   = reg_wr_i && (reg_addr_i == DW_COUNT) && reg_be_i[3];
  assign regs_clr = wr_ctl && reg_wdata_i[24 + CT_RST];
  assign state_en = done_i | reg_wr_i;

  // next state: completion first, then the register write on top
  always_comb begin
    civ_d = civ_q;
    lvi_d = lvi_q;
    st_d  = st_q;
    ctl_d = ctl_q;
    cnt_d = cnt_q;

    if (done_i && !st_q[ST_HALT]) begin
      st_d[ST_CELV] = 1'b0;
      if (done_ioc_i) st_d[ST_BCMP] = 1'b1;
      if (civ_q == lvi_q) begin
        st_d[ST_HALT] = 1'b1;
        st_d[ST_CELV] = 1'b1;
        st_d[ST_LVBC] = 1'b1;
      end else begin
        civ_d = civ_q + IDX_W'(1);
      end
      cnt_d = done_len_i;
    end

    if (wr_idx) begin
      if (reg_be_i[1]) begin
        lvi_d = reg_wdata_i[8 +: IDX_W];
        if (ctl_q[CT_RUN] && st_d[ST_HALT] && (civ_d != lvi_d)) begin
          st_d[ST_HALT] = 1'b0;
          st_d[ST_CELV] = 1'b0;
        end
      end
      if (reg_be_i[2]) begin
        for (int b = ST_LVBC; b <= ST_FERR; b++) begin
          if (reg_wdata_i[16 + b]) st_d[b] = 1'b0;
        end
      end
    end

    if (wr_ctl) begin
      if (regs_clr) begin
        civ_d = '0;
        lvi_d = '0;
        st_d  = ST_RESET;
        ctl_d = '0;
        cnt_d = '0;
      end else begin
        if (!reg_wdata_i[24 + CT_RUN]) begin
          st_d[ST_HALT] = 1'b1;
        end else if (!ctl_q[CT_RUN]) begin
          civ_d = '0;
          st_d[ST_HALT] = 1'b0;
        end
        ctl_d = reg_wdata_i[24 +: CTRL_W];
        ctl_d[CT_RST] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      civ_q <= '0;
      lvi_q <= '0;
      st_q  <= ST_RESET;
      ctl_q <= '0;
      cnt_q <= '0;
    end else if (state_en) begin
      civ_q <= civ_d;
      lvi_q <= lvi_d;
      st_q  <= st_d;
      ctl_q <= ctl_d;
      cnt_q <= cnt_d;
    end
  end

  assign piv_w = civ_q + IDX_W'(1);
  assign run_o = ctl_q[CT_RUN];

  arc_base_reg u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_base),
    .be_i    (reg_be_i),
    .wdata_i (reg_wdata_i),
    .clr_i   (regs_clr),
    .base_o  (base_w)
  );

  arc_irq_eval u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_old_i (st_q[ST_FERR:ST_LVBC]),
    .int_new_i (st_d[ST_FERR:ST_LVBC]),
    .lv_en_i   (ctl_d[CT_LVEN]),
    .bc_en_i   (ctl_d[CT_BCEN]),
    .irq_o     (irq_o)
  );

  arc_rd_mux #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_rd (
    .addr_i  (reg_addr_i),
    .base_i  (base_w),
    .civ_i   (civ_q),
    .lvi_i   (lvi_q),
    .piv_i   (piv_w),
    .st_i    (st_q),
    .ctl_i   (ctl_q),
    .cnt_i   (cnt_q),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/arc_checker.sv
module arc_checker
  import audio_ring_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [1:0]        reg_addr_i,
  input logic [3:0]        reg_be_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              done_i,
  input logic              irq_o,
  input logic [IDX_W-1:0]  civ_q,
  input logic [IDX_W-1:0]  lvi_q,
  input logic [STAT_W-1:0] st_q,
  input logic [CTRL_W-1:0] ctl_q,
  input logic [REG_W-1:0]  base_w
);
  // R12
  halt_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && st_q[ST_HALT] && !reg_wr_i) |=> ($stable(civ_q) && $stable(st_q)));

  // R8
  end_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !st_q[ST_HALT] && (civ_q == lvi_q) && !reg_wr_i) |=>
      (st_q[ST_HALT] && st_q[ST_CELV] && st_q[ST_LVBC] && $stable(civ_q)));

  // R7
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !st_q[ST_HALT] && (civ_q != lvi_q) && !reg_wr_i) |=>
      ((IDX_W'(civ_q - $past(civ_q)) == IDX_W'(1)) && !st_q[ST_CELV]));

  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(irq_o) |-> !$stable(st_q[ST_FERR:ST_LVBC]));

  // R5
  run_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && (reg_addr_i == 2'd2) && reg_be_i[3] && reg_wdata_i[24 + CT_RUN] &&
     !reg_wdata_i[24 + CT_RST] && !ctl_q[CT_RUN]) |=>
      ((civ_q == '0) && !st_q[ST_HALT] && ctl_q[CT_RUN]));

  // R2
  base_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && (reg_addr_i == 2'd0) && (reg_be_i == 4'hF)) |=>
      ((base_w[REG_W-1:BASE_LSB] == $past(reg_wdata_i[REG_W-1:BASE_LSB])) &&
       (base_w[BASE_LSB-1:0] == '0)));
endmodule

bind audio_ring_ctrl arc_checker #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_be_i    (reg_be_i),
  .reg_wdata_i (reg_wdata_i),
  .done_i      (done_i),
  .irq_o       (irq_o),
  .civ_q       (civ_q),
  .lvi_q       (lvi_q),
  .st_q        (st_q),
  .ctl_q       (ctl_q),
  .base_w      (base_w)
);

// File: tb/audio_ring_ctrl_bench.sv
`timescale 1ns/1ps
module audio_ring_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [3:0]  reg_be_i = 4'h0;
  logic [31:0] reg_wdata_i = 32'h0;
  logic [31:0] reg_rdata_o;
  logic        done_i = 1'b0;
  logic        done_ioc_i = 1'b0;
  logic [15:0] done_len_i = 16'h0;
  logic        run_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  audio_ring_ctrl u_audio_ring_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_be_i(reg_be_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .done_i(done_i), .done_ioc_i(done_ioc_i), .done_len_i(done_len_i),
    .run_o(run_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; reg_be_i = be;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_be_i = 4'h0;
  endtask

  task automatic pulse(input logic ioc, input logic [15:0] len);
    @(negedge clk_i);
    done_i = 1'b1; done_ioc_i = ioc; done_len_i = len;
    @(negedge clk_i);
    done_i = 1'b0; done_ioc_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr_i = a;
    #1;
    v = reg_rdata_o;
  endtask

  function automatic logic [31:0] idx_word(int civ, int lvi, logic [4:0] st);
    return {11'b0, st, 3'b0, 5'(lvi), 3'b0, 5'(civ)};
  endfunction

  function automatic logic [31:0] cnt_word(int civ, logic [4:0] ctl, int cnt);
    return {3'b0, ctl, 3'b0, 5'((civ + 1) % 32), 16'(cnt)};
  endfunction

  logic [31:0] v;

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e_civ;
    logic [4:0] e_st;
    int e_cnt;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2'd0, v); chk("R1 base", v, 32'h0);
    rd(2'd1, v); chk("R1 index/status", v, 32'h0001_0000);
    rd(2'd2, v); chk("R1 count/ctrl", v, 32'h0001_0000);
    chk("R1 run", {31'b0, run_o}, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R4 all-ones into status after reset
    wr(2'd1, 32'hFFFF_0000, 4'b1100);
    rd(2'd1, v); chk("R4 status ffff", v, 32'h0001_0000);

    // R11 read-only fields
    wr(2'd1, 32'h0000_00FF, 4'b0001);
    wr(2'd2, 32'h00FF_FFFF, 4'b0111);
    rd(2'd1, v); chk("R11 civ ro", v, 32'h0001_0000);
    rd(2'd2, v); chk("R11 piv/count ro", v, 32'h0001_0000);

    // R2 base alignment and byte lanes
    wr(2'd0, 32'h5555_555F, 4'hF);
    rd(2'd0, v); chk("R2 base dword", v, 32'h5555_5558);
    wr(2'd0, 32'hFFFF_FFFF, 4'b0001);
    rd(2'd0, v); chk("R2 base lane0", v, 32'h5555_55F8);
    wr(2'd0, 32'hA0A0_0000, 4'b1000);
    rd(2'd0, v); chk("R2 base lane3", v, 32'hA055_55F8);

    // R3 last-valid modulo 32
    wr(2'd1, 32'h0000_2500, 4'b0010);
    rd(2'd1, v); chk("R3 lvi mod", v, 32'h0001_0500);

    // R12 completion while halted and stopped
    pulse(1'b1, 16'h1234);
    rd(2'd1, v); chk("R12 halted idx", v, 32'h0001_0500);
    rd(2'd2, v); chk("R12 halted cnt", v, 32'h0001_0000);

    // R5 start
    wr(2'd2, 32'h0100_0000, 4'b1000);
    rd(2'd1, v); chk("R5 start idx", v, 32'h0000_0500);
    rd(2'd2, v); chk("R5 start piv", v, 32'h0101_0000);
    chk("R5 run out", {31'b0, run_o}, 32'h1);

    // R7 full ring walk with last valid at 31
    wr(2'd1, 32'h0000_1F00, 4'b0010);
    e_civ = 0; e_st = 5'b0; e_cnt = 0;
    for (int i = 0; i < 31; i++) begin
      pulse(1'(i % 2), 16'(i * 3 + 7));
      e_civ = e_civ + 1;
      if (i % 2 == 1) e_st[3] = 1'b1;
      e_cnt = i * 3 + 7;
      rd(2'd1, v); chk("R7 walk idx", v, idx_word(e_civ, 31, e_st));
      rd(2'd2, v); chk("R7 walk cnt", v, cnt_word(e_civ, 5'h01, e_cnt));
      chk("R7 irq off", {31'b0, irq_o}, 32'h0);
    end

    // R8 end of list at 31
    pulse(1'b0, 16'd500);
    e_st = 5'b01111;
    rd(2'd1, v); chk("R8 stop", v, idx_word(31, 31, e_st));
    rd(2'd2, v); chk("R8 count", v, cnt_word(31, 5'h01, 500));

    // R12 again while halted but running
    pulse(1'b1, 16'd9);
    rd(2'd1, v); chk("R12 run halted", v, idx_word(31, 31, e_st));

    // R9 restart by moving last valid, then wrap through 0
    wr(2'd1, 32'h0000_0300, 4'b0010);
    e_st = 5'b01100;
    rd(2'd1, v); chk("R9 restart", v, idx_word(31, 3, e_st));
    for (int i = 0; i < 4; i++) begin
      pulse(1'b0, 16'(40 + i));
      rd(2'd1, v); chk("R7 wrap", v, idx_word(i, 3, e_st));
    end
    pulse(1'b0, 16'd60);
    e_st = 5'b01111;
    rd(2'd1, v); chk("R8 stop at 3", v, idx_word(3, 3, e_st));

    // R9 no restart when new value equals current index
    wr(2'd1, 32'h0000_0300, 4'b0010);
    rd(2'd1, v); chk("R9 same idx", v, idx_word(3, 3, e_st));

    // R4 clear-on-one bits
    wr(2'd1, 32'hFFFF_0000, 4'b0100);
    rd(2'd1, v); chk("R4 w1c", v, idx_word(3, 3, 5'b00011));

    // R5 stop
    wr(2'd2, 32'h0000_0000, 4'b1000);
    chk("R5 stop run", {31'b0, run_o}, 32'h0);
    rd(2'd1, v); chk("R5 stop halt", v, idx_word(3, 3, 5'b00011));

    // R10 interrupt evaluation
    wr(2'd2, 32'h1100_0000, 4'b1000);           // run + buffer-completion enable
    rd(2'd1, v); chk("R5 restart civ0", v, idx_word(0, 3, 5'b00010));
    pulse(1'b1, 16'd1);
    chk("R10 bc irq", {31'b0, irq_o}, 32'h1);
    wr(2'd1, 32'h0008_0000, 4'b0100);
    chk("R10 clear irq", {31'b0, irq_o}, 32'h0);
    wr(2'd2, 32'h0100_0000, 4'b1000);           // enable off
    pulse(1'b1, 16'd2);
    chk("R10 disabled", {31'b0, irq_o}, 32'h0);
    wr(2'd2, 32'h1900_0000, 4'b1000);           // both enables, no status change
    chk("R10 ctrl only", {31'b0, irq_o}, 32'h0);
    pulse(1'b0, 16'd3);                          // civ 2 -> 3, int bits unchanged
    chk("R10 no change", {31'b0, irq_o}, 32'h0);
    rd(2'd1, v); chk("R10 idx", v, idx_word(3, 3, 5'b01000));
    pulse(1'b0, 16'd4);                          // end of list sets last-valid cmp
    chk("R10 lvb irq", {31'b0, irq_o}, 32'h1);

    // R6 register reset
    wr(2'd2, 32'h0200_0000, 4'b1000);
    rd(2'd0, v); chk("R6 base", v, 32'h0);
    rd(2'd1, v); chk("R6 idx", v, 32'h0001_0000);
    rd(2'd2, v); chk("R6 cnt", v, 32'h0001_0000);
    chk("R6 run", {31'b0, run_o}, 32'h0);
    chk("R6 irq", {31'b0, irq_o}, 32'h0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule